// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a virtual address into a physical address with one lookup in a page table that sits in memory. A request carries a 15-bit virtual address and an access kind: read, write or instruction fetch. The upper five bits are the virtual page number and the lower ten bits are the page offset, because pages are 1 KB. The block adds the page number to a base register to get the entry address. It reads that entry through a read port whose latency can vary. It checks the valid bit and the access rights. On success it returns the entry's 3-bit frame number joined to the unchanged offset, which gives a 13-bit physical address.

A missing page and a rights violation each return their own fault code, with the physical address forced to zero. Each process can have its own table, because software changes the whole mapping by writing the base register. A write that lands while a translation is in flight affects only requests accepted after it. The translator handles one request at a time.

The request and response sides are valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. A response stays valid and unchanged until it is taken with `rsp_ready`, so a slow consumer stalls the block. The table read port follows the same rule on its request side: `mem_rd_valid` and its address hold until `mem_rd_ready`. The data comes back one or more cycles later, flagged by a single-cycle `mem_rsp_valid`.

Top module: `pt_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_rd_valid` are 0.
- R2: The table read address is (base + virtual page number) modulo 2^TA_W. The page number is bits 14:10 of `req_vaddr`, and the base is the register value at the time the request is accepted.
- R3: A table entry holds the valid bit in bit 0, the rights code in bits 2:1 and the frame number in bits 5:3. For an allowed access, `rsp_paddr` is {frame number, `req_vaddr[9:0]`} and `rsp_fault` is 0.
- R4: An entry whose bit 0 is 0 gives `rsp_fault` = 1 (not present), whatever its rights bits say.
- R5: The rights codes are 0 read-only, 1 read/write, 2 execute-only and 3 reserved. The access kinds on `req_acc` are 0 read, 1 write, 2 fetch and 3 reserved. A read is allowed for rights 0 and 1, a write only for rights 1, and a fetch only for rights 2. Every other combination of a valid entry gives `rsp_fault` = 2 (protection). Code 3 is never produced.
- R6: From the cycle a request is accepted until its response is taken, `req_ready` stays 0, so at most one translation is outstanding.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds with `rsp_paddr` and `rsp_fault` unchanged.
- R8: A write to the base register (`base_we`) changes the table used by later requests. It does not change the table used by a request that has already been accepted.
- R9: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request holds with `mem_rd_addr` unchanged.
- R10: Whenever `rsp_fault` is nonzero, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | TA_W (8) | New table base address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | VA_W (15) | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | PA_W (13) | Physical address, zero on a fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | TA_W (8) | Table entry address |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | ENT_W (6) | Table entry read back |

## Verification
The test runs the same page numbers under every access kind against entries of each rights code. This separates a correct rights check from one that swaps read-only and read/write or treats the reserved code as allowed. An entry that is not valid but has read/write rights shows whether the valid check takes priority. A base near the top of the table address range with the highest page number checks that the entry address wraps. A base write made while a request waits on a slow memory shows that the in-flight request keeps the old table and the next request uses the new one. Irregular ready patterns on both the memory and response sides exercise the hold rules.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  // entry field layout shared by the checker and the tables software builds
  localparam int unsigned EF_VALID  = 0;
  localparam int unsigned EF_RT_LSB = 1;
  localparam int unsigned EF_PPN_LSB = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    RT_RO   = 2'd0,
    RT_RW   = 2'd1,
    RT_EX   = 2'd2,
    RT_RSVD = 2'd3
  } rights_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } state_e;

endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int unsigned TA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TA_W-1:0] wr_data,
  output logic [TA_W-1:0] base
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
    end else if (wr_en) begin
      base <= wr_data;
    end
  end

endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int unsigned VPN_W = 5,
  parameter int unsigned TA_W  = 8
) (
  input  logic [TA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  output logic [TA_W-1:0]  addr
);

  // index into the table; wraps within the table address space
  always_comb begin
    addr = base + TA_W'(vpn);
  end

endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_xlate_pkg::*;
#(
  parameter int unsigned PPN_W = 3,
  localparam int unsigned ENT_W = EF_PPN_LSB + PPN_W
) (
  input  logic [ENT_W-1:0] entry,
  input  acc_e             acc,
  output fault_e           fault,
  output logic [PPN_W-1:0] ppn
);

  logic    present;
  rights_e rights;
  logic    allowed;

  always_comb begin
    present = entry[EF_VALID];
    rights  = rights_e'(entry[EF_RT_LSB +: 2]);
    ppn     = entry[EF_PPN_LSB +: PPN_W];
    unique case (acc)
      ACC_READ:  allowed = (rights == RT_RO) || (rights == RT_RW);
      ACC_WRITE: allowed = (rights == RT_RW);
      ACC_FETCH: allowed = (rights == RT_EX);
      default:   allowed = 1'b0;
    endcase
    if (!present) begin
      fault = FLT_ABSENT;
    end else if (!allowed) begin
      fault = FLT_PROT;
    end else begin
      fault = FLT_NONE;
    end
  end

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter int unsigned OFF_W = 10,
  parameter int unsigned VPN_W = 5,
  parameter int unsigned PPN_W = 3,
  parameter int unsigned TA_W  = 8,
  localparam int unsigned VA_W  = VPN_W + OFF_W,
  localparam int unsigned PA_W  = PPN_W + OFF_W,
  localparam int unsigned ENT_W = EF_PPN_LSB + PPN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [TA_W-1:0]  base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [TA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data
);

  state_e           state_q;
  logic [TA_W-1:0]  base;
  logic [TA_W-1:0]  eaddr;
  logic [TA_W-1:0]  eaddr_q;
  logic [OFF_W-1:0] off_q;
  acc_e             acc_q;
  fault_e           chk_fault;
  logic [PPN_W-1:0] chk_ppn;
  logic [PA_W-1:0]  paddr_q;
  fault_e           fault_q;

  pt_base_reg #(.TA_W(TA_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_we),
    .wr_data (base_wdata),
    .base    (base)
  );

  pt_entry_addr #(.VPN_W(VPN_W), .TA_W(TA_W)) u_eaddr (
    .base (base),
    .vpn  (req_vaddr[VA_W-1:OFF_W]),
    .addr (eaddr)
  );

  pt_perm_check #(.PPN_W(PPN_W)) u_perm (
    .entry (mem_rsp_data),
    .acc   (acc_q),
    .fault (chk_fault),
    .ppn   (chk_ppn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      eaddr_q <= '0;
      off_q   <= '0;
      acc_q   <= ACC_READ;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            eaddr_q <= eaddr;
            off_q   <= req_vaddr[OFF_W-1:0];
            acc_q   <= acc_e'(req_acc);
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_rd_ready) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            fault_q <= chk_fault;
            paddr_q <= (chk_fault == FLT_NONE) ? {chk_ppn, off_q} : '0;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready    = (state_q == ST_IDLE);
    mem_rd_valid = (state_q == ST_ISSUE);
    mem_rd_addr  = eaddr_q;
    rsp_valid    = (state_q == ST_RESP);
    rsp_paddr    = paddr_q;
    rsp_fault    = fault_q;
  end

endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
  parameter int unsigned PA_W = 13,
  parameter int unsigned TA_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault,
  input logic            mem_rd_valid,
  input logic            mem_rd_ready,
  input logic [TA_W-1:0] mem_rd_addr
);

  AST_ACCEPT_READS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_rd_valid && !req_ready); // R2

  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'd3); // R5

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid || mem_rd_valid |-> !req_ready); // R6

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R9

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == '0); // R10

endmodule

bind pt_xlate pt_xlate_chk #(.PA_W(PA_W), .TA_W(TA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_paddr    (rsp_paddr),
  .rsp_fault    (rsp_fault),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr)
);

// File: tb/pt_xlate_tb.sv
`timescale 1ns/1ps
module pt_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [7:0]  base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [14:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [12:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [7:0]  mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [5:0]  mem_rsp_data = '0;

  always #4 clk = ~clk;

  pt_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  typedef struct {
    logic [12:0] paddr;
    logic [1:0]  fault;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [7:0]  addr_q[$];
  logic [5:0]  tbl [256];
  logic [7:0]  tb_base = '0;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // driver: compute expectation from the table model, then offer request
  task automatic send(logic [4:0] vpn, logic [9:0] off, logic [1:0] acc, string tag);
    exp_t       e;
    logic [7:0] ea;
    logic [5:0] ent;
    logic       ok;
    ea  = tb_base + {3'b0, vpn};
    ent = tbl[ea];
    case (acc)
      2'd0: ok = !ent[2];
      2'd1: ok = (ent[2:1] == 2'b01);
      2'd2: ok = (ent[2:1] == 2'b10);
      default: ok = 1'b0;
    endcase
    if (!ent[0])   begin e.fault = 2'd1; e.paddr = '0; end
    else if (!ok)  begin e.fault = 2'd2; e.paddr = '0; end
    else           begin e.fault = 2'd0; e.paddr = {ent[5:3], off}; end
    e.tag = tag;
    exp_q.push_back(e);
    addr_q.push_back(ea);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    req_acc   = acc;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_base(logic [7:0] b);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
    tb_base = b;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // memory model: decides ready at negedge, answers after 1..3 cycles
  int         lat = 0;
  logic [7:0] lat_addr = '0;
  logic       rd_stall = 1'b0;
  logic [7:0] rd_stall_addr = '0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = tbl[lat_addr];
      end
    end
    if (rd_stall && mem_rd_valid) chk("R9 read address held", mem_rd_addr, rd_stall_addr);
    mem_rd_ready = (cyc % 3) != 1;
    rd_stall = mem_rd_valid && !mem_rd_ready;
    rd_stall_addr = mem_rd_addr;
    if (mem_rd_valid && mem_rd_ready) begin
      if (addr_q.size() == 0) chk("R2 unexpected read", 1, 0);
      else chk("R2 entry address", mem_rd_addr, addr_q.pop_front());
      lat_addr = mem_rd_addr;
      lat = 1 + (cyc % 3);
    end
  end

  // monitor: compare each response when it is taken
  logic        holding = 1'b0;
  logic [12:0] hold_p = '0;
  logic [1:0]  hold_f = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (holding) begin
        chk("R7 held valid", rsp_valid, 1);
        chk("R7 held paddr", rsp_paddr, hold_p);
        chk("R7 held fault", rsp_fault, hold_f);
      end
      rsp_ready = (cyc % 4) != 2;
      holding = rsp_valid && !rsp_ready;
      hold_p = rsp_paddr;
      hold_f = rsp_fault;
      if (rsp_valid) chk("R6 no accept while busy", req_ready, 0);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk("R3 unexpected response", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.tag, " fault"}, rsp_fault, e.fault);
          chk(e.fault != 0 ? {e.tag, " R10 paddr"} : {e.tag, " paddr"}, rsp_paddr, e.paddr);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) tbl[i] = '0;
    // entry = {ppn[2:0], rights[1:0], valid}
    tbl[8'h10] = {3'd5, 2'd1, 1'b1};
    tbl[8'h11] = {3'd2, 2'd0, 1'b1};
    tbl[8'h12] = {3'd7, 2'd2, 1'b1};
    tbl[8'h13] = {3'd3, 2'd1, 1'b0};
    tbl[8'h14] = {3'd4, 2'd3, 1'b1};
    tbl[8'h0F] = {3'd6, 2'd1, 1'b1};
    tbl[8'h40] = {3'd1, 2'd0, 1'b1};
    repeat (3) @(negedge clk);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mem_rd_valid", mem_rd_valid, 0);
    rst_n = 1'b1;
    set_base(8'h10);
    send(5'd0, 10'h3A5, 2'd0, "R3 rw read");
    send(5'd0, 10'h001, 2'd1, "R3 rw write");
    send(5'd0, 10'h2F0, 2'd2, "R5 rw fetch");
    send(5'd1, 10'h155, 2'd0, "R3 ro read");
    send(5'd1, 10'h155, 2'd1, "R5 ro write");
    send(5'd2, 10'h3FF, 2'd2, "R3 ex fetch");
    send(5'd2, 10'h000, 2'd0, "R5 ex read");
    send(5'd3, 10'h0AA, 2'd0, "R4 absent read");
    send(5'd3, 10'h0AA, 2'd2, "R4 absent fetch");
    send(5'd4, 10'h123, 2'd0, "R5 reserved rights");
    send(5'd0, 10'h123, 2'd3, "R5 reserved kind");
    drain();
    set_base(8'hF0);
    send(5'd31, 10'h2C3, 2'd1, "R2 wrap write");
    drain();
    set_base(8'h10);
    send(5'd0, 10'h077, 2'd0, "R8 in-flight old base");
    base_we = 1'b1;
    base_wdata = 8'h40;
    @(negedge clk);
    base_we = 1'b0;
    tb_base = 8'h40;
    send(5'd0, 10'h077, 2'd0, "R8 new base");
    send(5'd0, 10'h077, 2'd1, "R8 new base write");
    drain();
    repeat (4) @(negedge clk);
    chk("R1 idle again", req_ready, 1);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule